// File: doc/BRIEF.md
# FPGA Configuration Scrubbing Controller

This block loads a target FPGA's configuration from a flash holding a golden image. It then keeps that configuration correct while the target runs. A host command starts the load. The golden image is written into the target frame by frame through a byte-wide configuration port, with a few pad bytes after each frame to flush the target's write pipeline.

Once loaded, the controller reads the frames back without end, in ascending order, and compares each byte against flash. Every flash word carries one configuration byte and one mask byte, bit-interleaved. Only bits whose mask is set take part in the compare.

A frame with any unmasked difference is rewritten from flash with its pad bytes. The port then returns to read mode, a sticky interrupt is raised, the correction count and last-fixed frame address are updated, and readback restarts at the same frame to verify the repair. The host reads status through a strobe that also clears the interrupt. The sequencing state is held in triple-voted registers.

Top module: `cfg_scrub_ctrl`

## Requirements
- R1: After reset the mode output is 0 (idle), no target or flash strobe is active, irq_o is low and the correction count is 0.
- R2: A load command, taken only in idle or loaded, raises write mode for one cycle without a strobe. It then writes frames 0 to FRAMES-1 in order: for each frame, bytes 0 to FRAME_BYTES-1 followed by PAD_BYTES pad bytes of value 0 at byte indices FRAME_BYTES and up. Write mode then drops for one strobe-free cycle. Mode reads 1 during the load.
- R3: Flash word bit 2k is configuration bit k and bit 2k+1 is mask bit k; the byte written to the target is the configuration byte of word frame*FRAME_BYTES+byte.
- R4: At the end of a load, auto_scrub_i high starts readback at frame 0 (mode 2). Low leaves the block loaded (mode 0) until a scrub command.
- R5: Readback asserts tgt_rd_o with write mode low every cycle, covering bytes 0 to FRAME_BYTES-1 of each frame and frames in ascending order. It wraps from the last frame to frame 0.
- R6: A difference between a read byte and its configuration byte counts only in bits whose mask bit is 1; masked differences never start a correction.
- R7: A frame with an unmasked difference is corrected. The sequence is one write-mode cycle, the frame's bytes plus pads as in R2, and one read-mode cycle with no strobe. Mode reads 3 throughout. Readback then resumes at byte 0 of the same frame.
- R8: Each correction sets irq_o one cycle after the read-mode cycle. It also sets the last-fixed frame to the corrected frame and increments the count, which saturates at all ones.
- R9: stat_rd_i clears irq_o on the next edge; if a correction completes in the same cycle, the set wins.
- R10: A scrub command in idle and a load command during readback or correction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (50 MHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_load_i | input | 1 | Host command: load the configuration |
| cmd_scrub_i | input | 1 | Host command: start readback from loaded state |
| auto_scrub_i | input | 1 | Start readback automatically after a load |
| stat_rd_i | input | 1 | Host status read strobe, clears irq_o |
| stat_mode_o | output | 2 | 0 idle/loaded, 1 load, 2 readback, 3 correction |
| stat_fix_cnt_o | output | CNT_W | Saturating count of corrected frames |
| stat_last_frame_o | output | clog2(FRAMES) | Address of the last corrected frame |
| irq_o | output | 1 | Sticky correction interrupt |
| flash_rd_o | output | 1 | Flash read enable |
| flash_addr_o | output | clog2(FRAMES*FRAME_BYTES) | Flash word address |
| flash_data_i | input | 16 | Flash word, same-cycle read, config/mask interleaved |
| tgt_write_mode_o | output | 1 | Target port direction, 1 = write |
| tgt_wr_o | output | 1 | Target write strobe |
| tgt_rd_o | output | 1 | Target read strobe |
| tgt_frame_o | output | clog2(FRAMES) | Target frame address |
| tgt_byte_o | output | clog2(FRAME_BYTES+PAD_BYTES) | Byte index within frame (pads above FRAME_BYTES-1) |
| tgt_data_o | output | 8 | Target write data |
| tgt_data_i | input | 8 | Target read data, same cycle |

## Verification
The bench targets a flip in the last frame. A design that restarted at frame 0, or advanced past the fixed frame, would read the wrong frame right after the interrupt. It also flips a bit whose mask is clear: a design that ignored the mask would start a spurious correction and bump the count. Further cases are a correction finishing while the host holds the status strobe, where a clear-wins design would never show the interrupt, and a count pushed past its top, where a wrapping counter would return to zero. Commands issued in the wrong mode check that a stray load cannot overwrite a running target.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FLASH_W = 2 * BYTE_W;

  typedef enum logic [3:0] {
    S_IDLE, S_LOADED, S_UP_SW, S_UP_WR, S_UP_RD,
    S_RB, S_FX_SW, S_FX_WR, S_FX_RD
  } st_e;
  localparam int unsigned ST_W = 4;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_LOAD  = 2'd1,
    MD_SCRUB = 2'd2,
    MD_FIX   = 2'd3
  } mode_e;
endpackage

// File: rtl/scrub_tmr_reg.sv
module scrub_tmr_reg #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // each copy loads the voted next value, so a single upset heals on the next edge
  for (genvar i = 0; i < 3; i++) begin : g_copy
    logic [W-1:0] r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r <= RST;
      else         r <= d_i;
    end
  end

  assign q_o = (g_copy[0].r & g_copy[1].r) |
               (g_copy[0].r & g_copy[2].r) |
               (g_copy[1].r & g_copy[2].r);
endmodule

// File: rtl/scrub_frame_cmp.sv
module scrub_frame_cmp import scrub_pkg::*; (
  input  logic [FLASH_W-1:0] word_i,
  input  logic [BYTE_W-1:0]  rd_i,
  output logic [BYTE_W-1:0]  cfg_o,
  output logic               diff_o
);
  logic [BYTE_W-1:0] mask;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_split
    assign cfg_o[k] = word_i[2*k];
    assign mask[k]  = word_i[2*k+1];
  end

  assign diff_o = |((rd_i ^ cfg_o) & mask);
endmodule

// File: rtl/cfg_scrub_ctrl.sv
module cfg_scrub_ctrl import scrub_pkg::*; #(
  parameter int unsigned FRAMES      = 64,
  parameter int unsigned FRAME_BYTES = 16,
  parameter int unsigned PAD_BYTES   = 4,
  parameter int unsigned CNT_W       = 8
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      cmd_load_i,
  input  logic                                      cmd_scrub_i,
  input  logic                                      auto_scrub_i,
  input  logic                                      stat_rd_i,
  output logic [1:0]                                stat_mode_o,
  output logic [CNT_W-1:0]                          stat_fix_cnt_o,
  output logic [$clog2(FRAMES)-1:0]                 stat_last_frame_o,
  output logic                                      irq_o,
  output logic                                      flash_rd_o,
  output logic [$clog2(FRAMES*FRAME_BYTES)-1:0]     flash_addr_o,
  input  logic [15:0]                               flash_data_i,
  output logic                                      tgt_write_mode_o,
  output logic                                      tgt_wr_o,
  output logic                                      tgt_rd_o,
  output logic [$clog2(FRAMES)-1:0]                 tgt_frame_o,
  output logic [$clog2(FRAME_BYTES+PAD_BYTES)-1:0]  tgt_byte_o,
  output logic [7:0]                                tgt_data_o,
  input  logic [7:0]                                tgt_data_i
);
  localparam int unsigned FR_W = $clog2(FRAMES);
  localparam int unsigned BY_W = $clog2(FRAME_BYTES + PAD_BYTES);
  localparam int unsigned FA_W = $clog2(FRAMES * FRAME_BYTES);
  localparam logic [FR_W-1:0] FR_LAST = FR_W'(FRAMES - 1);
  localparam logic [BY_W-1:0] WR_LAST = BY_W'(FRAME_BYTES + PAD_BYTES - 1);
  localparam logic [BY_W-1:0] RB_LAST = BY_W'(FRAME_BYTES - 1);
  localparam logic [FA_W-1:0] FB_A    = FA_W'(FRAME_BYTES);

  st_e              st_q, st_d;
  logic [ST_W-1:0]  st_raw;
  logic [FR_W-1:0]  fr_q, fr_d;
  logic [BY_W-1:0]  by_q, by_d;
  logic             mis_q, mis_d;
  logic             fix;
  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FR_W-1:0]  last_q;
  logic [7:0]       cfg_byte;
  logic             diff;
  logic             in_frame;
  logic             wr_st;

  scrub_tmr_reg #(.W(ST_W), .RST(ST_W'(S_IDLE))) u_st (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (st_d),
    .q_o   (st_raw)
  );
  assign st_q = st_e'(st_raw);

  scrub_frame_cmp u_cmp (
    .word_i(flash_data_i),
    .rd_i  (tgt_data_i),
    .cfg_o (cfg_byte),
    .diff_o(diff)
  );

  always_comb begin
    st_d  = st_q;
    fr_d  = fr_q;
    by_d  = by_q;
    mis_d = mis_q;
    fix   = 1'b0;
    unique case (st_q)
      S_IDLE, S_LOADED: begin
        if (cmd_load_i) begin
          st_d = S_UP_SW;
          fr_d = '0;
          by_d = '0;
        end else if (st_q == S_LOADED && cmd_scrub_i) begin
          st_d  = S_RB;
          fr_d  = '0;
          by_d  = '0;
          mis_d = 1'b0;
        end
      end
      S_UP_SW: begin
        st_d = S_UP_WR;
        by_d = '0;
      end
      S_UP_WR: begin
        if (by_q == WR_LAST) begin
          by_d = '0;
          if (fr_q == FR_LAST) st_d = S_UP_RD;
          else                 fr_d = fr_q + FR_W'(1);
        end else begin
          by_d = by_q + BY_W'(1);
        end
      end
      S_UP_RD: begin
        st_d  = auto_scrub_i ? S_RB : S_LOADED;
        fr_d  = '0;
        by_d  = '0;
        mis_d = 1'b0;
      end
      S_RB: begin
        if (by_q == RB_LAST) begin
          by_d  = '0;
          mis_d = 1'b0;
          if (mis_q || diff)       st_d = S_FX_SW;
          else if (fr_q == FR_LAST) fr_d = '0;
          else                      fr_d = fr_q + FR_W'(1);
        end else begin
          by_d  = by_q + BY_W'(1);
          mis_d = mis_q | diff;
        end
      end
      S_FX_SW: begin
        st_d = S_FX_WR;
        by_d = '0;
      end
      S_FX_WR: begin
        if (by_q == WR_LAST) begin
          st_d = S_FX_RD;
          by_d = '0;
        end else begin
          by_d = by_q + BY_W'(1);
        end
      end
      S_FX_RD: begin
        st_d  = S_RB;
        by_d  = '0;
        mis_d = 1'b0;
        fix   = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q  <= '0;
      by_q  <= '0;
      mis_q <= 1'b0;
    end else begin
      fr_q  <= fr_d;
      by_q  <= by_d;
      mis_q <= mis_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (fix) begin
      irq_q  <= 1'b1;
      last_q <= fr_q;
      if (!(&cnt_q)) cnt_q <= cnt_q + CNT_W'(1);
    end else if (stat_rd_i) begin
      irq_q <= 1'b0;
    end
  end

  assign wr_st    = (st_q == S_UP_WR) || (st_q == S_FX_WR);
  assign in_frame = (by_q <= RB_LAST);

  assign tgt_wr_o         = wr_st;
  assign tgt_rd_o         = (st_q == S_RB);
  assign tgt_write_mode_o = wr_st || (st_q == S_UP_SW) || (st_q == S_FX_SW);
  assign tgt_frame_o      = fr_q;
  assign tgt_byte_o       = by_q;
  assign tgt_data_o       = (wr_st && in_frame) ? cfg_byte : 8'h00;

  assign flash_rd_o   = (wr_st && in_frame) || (st_q == S_RB);
  assign flash_addr_o = FA_W'(fr_q) * FB_A + (in_frame ? FA_W'(by_q) : '0);

  always_comb begin
    unique case (st_q)
      S_UP_SW, S_UP_WR, S_UP_RD: stat_mode_o = MD_LOAD;
      S_RB:                      stat_mode_o = MD_SCRUB;
      S_FX_SW, S_FX_WR, S_FX_RD: stat_mode_o = MD_FIX;
      default:                   stat_mode_o = MD_IDLE;
    endcase
  end

  assign irq_o             = irq_q;
  assign stat_fix_cnt_o    = cnt_q;
  assign stat_last_frame_o = last_q;
endmodule

// File: rtl/cfg_scrub_chk.sv
module cfg_scrub_chk #(
  parameter int unsigned FRAMES      = 64,
  parameter int unsigned FRAME_BYTES = 16,
  parameter int unsigned PAD_BYTES   = 4,
  parameter int unsigned CNT_W       = 8
) (
  input logic                                     clk_i,
  input logic                                     rst_ni,
  input logic [1:0]                               stat_mode_o,
  input logic [CNT_W-1:0]                         stat_fix_cnt_o,
  input logic                                     irq_o,
  input logic                                     tgt_write_mode_o,
  input logic                                     tgt_wr_o,
  input logic                                     tgt_rd_o,
  input logic [$clog2(FRAMES)-1:0]                tgt_frame_o,
  input logic [$clog2(FRAME_BYTES+PAD_BYTES)-1:0] tgt_byte_o
);
  a_r7_wr_in_write_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_wr_o |-> tgt_write_mode_o);

  a_r5_rd_in_read_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rd_o |-> (!tgt_write_mode_o && !tgt_wr_o));

  a_r7_settle_before_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_write_mode_o) |-> !tgt_wr_o);

  a_r7_settle_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_write_mode_o) |-> !tgt_rd_o);

  a_r5_byte_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rd_o |-> (32'(tgt_byte_o) < FRAME_BYTES));

  a_r5_frame_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_rd_o || tgt_wr_o) |-> (32'(tgt_frame_o) < FRAMES));

  a_r5_scrub_mode_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_mode_o == 2'd2) |-> tgt_rd_o);

  a_r8_cnt_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rd_o |=> (stat_fix_cnt_o >= $past(stat_fix_cnt_o)));

  a_r8_irq_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((stat_fix_cnt_o != $past(stat_fix_cnt_o)) || (&stat_fix_cnt_o)));
endmodule

bind cfg_scrub_ctrl cfg_scrub_chk #(
  .FRAMES(FRAMES), .FRAME_BYTES(FRAME_BYTES), .PAD_BYTES(PAD_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .stat_mode_o     (stat_mode_o),
  .stat_fix_cnt_o  (stat_fix_cnt_o),
  .irq_o           (irq_o),
  .tgt_write_mode_o(tgt_write_mode_o),
  .tgt_wr_o        (tgt_wr_o),
  .tgt_rd_o        (tgt_rd_o),
  .tgt_frame_o     (tgt_frame_o),
  .tgt_byte_o      (tgt_byte_o)
);

// File: tb/tb_cfg_scrub_ctrl.sv
module tb_cfg_scrub_ctrl;
  localparam int FR = 4;
  localparam int FB = 4;
  localparam int PB = 2;
  localparam int CW = 2;
  localparam int FR_W = $clog2(FR);
  localparam int BY_W = $clog2(FB + PB);
  localparam int FA_W = $clog2(FR * FB);
  localparam int NB = FR * FB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_load = 1'b0, cmd_scrub = 1'b0, auto_scrub = 1'b0, stat_rd = 1'b0;
  logic [1:0] mode;
  logic [CW-1:0] fix_cnt;
  logic [FR_W-1:0] last_fr, t_frame;
  logic irq, f_rd, t_wm, t_wr, t_rd;
  logic [FA_W-1:0] f_addr;
  logic [15:0] f_data;
  logic [BY_W-1:0] t_byte;
  logic [7:0] t_dout, t_din;

  logic [7:0] gcfg [NB];
  logic [7:0] gmask [NB];
  logic [15:0] fmem [NB];
  logic [7:0] tmem [NB];

  int n_chk = 0, n_bad = 0;
  int n_cfg_wr = 0, n_pad_wr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cfg_scrub_ctrl #(.FRAMES(FR), .FRAME_BYTES(FB), .PAD_BYTES(PB), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_load_i(cmd_load), .cmd_scrub_i(cmd_scrub), .auto_scrub_i(auto_scrub), .stat_rd_i(stat_rd),
    .stat_mode_o(mode), .stat_fix_cnt_o(fix_cnt), .stat_last_frame_o(last_fr), .irq_o(irq),
    .flash_rd_o(f_rd), .flash_addr_o(f_addr), .flash_data_i(f_data),
    .tgt_write_mode_o(t_wm), .tgt_wr_o(t_wr), .tgt_rd_o(t_rd), .tgt_frame_o(t_frame),
    .tgt_byte_o(t_byte), .tgt_data_o(t_dout), .tgt_data_i(t_din)
  );

  // flash and target frame memory
  assign f_data = fmem[f_addr];
  assign t_din  = (int'(t_byte) < FB) ? tmem[int'(t_frame) * FB + int'(t_byte)] : 8'h00;

  always @(posedge clk)
    if (t_wr && t_wm && int'(t_byte) < FB) tmem[int'(t_frame) * FB + int'(t_byte)] <= t_dout;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle,1 loaded,2 wr-switch,3 load write,4 rd-switch,
  // 5 readback,6 fix wr-switch,7 fix write,8 fix rd-switch
  int m_ph = 0, m_fr = 0, m_by = 0, m_cnt = 0, m_last = 0;
  bit m_mis = 0, m_irq = 0;

  always @(posedge clk) begin
    automatic int idx = m_fr * FB + m_by;
    automatic bit d;
    if (!rst_n) begin
      m_ph = 0; m_fr = 0; m_by = 0; m_mis = 0; m_irq = 0; m_cnt = 0; m_last = 0;
    end else begin
      automatic bit set_irq = 0;
      case (m_ph)
        0, 1: if (cmd_load) begin m_ph = 2; m_fr = 0; m_by = 0; end
              else if (m_ph == 1 && cmd_scrub) begin m_ph = 5; m_fr = 0; m_by = 0; m_mis = 0; end
        2: begin m_ph = 3; m_by = 0; end
        3: if (m_by == FB + PB - 1) begin
             m_by = 0;
             if (m_fr == FR - 1) m_ph = 4; else m_fr++;
           end else m_by++;
        4: begin m_ph = auto_scrub ? 5 : 1; m_fr = 0; m_by = 0; m_mis = 0; end
        5: begin
             d = ((tmem[idx] ^ gcfg[idx]) & gmask[idx]) != 8'h00;
             if (m_by == FB - 1) begin
               if (m_mis || d) m_ph = 6; else m_fr = (m_fr + 1) % FR;
               m_by = 0; m_mis = 0;
             end else begin m_by++; m_mis = m_mis | d; end
           end
        6: begin m_ph = 7; m_by = 0; end
        7: if (m_by == FB + PB - 1) begin m_ph = 8; m_by = 0; end else m_by++;
        8: begin
             m_ph = 5; m_by = 0; m_mis = 0; set_irq = 1;
             m_last = m_fr;
             if (m_cnt < (1 << CW) - 1) m_cnt++;
           end
        default: m_ph = 0;
      endcase
      if (set_irq) m_irq = 1; else if (stat_rd) m_irq = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic bit e_wr = (m_ph == 3) || (m_ph == 7);
      automatic bit e_rd = (m_ph == 5);
      automatic bit e_wm = (m_ph == 2) || (m_ph == 3) || (m_ph == 6) || (m_ph == 7);
      automatic int e_md = (m_ph >= 2 && m_ph <= 4) ? 1 : (m_ph == 5) ? 2 : (m_ph >= 6) ? 3 : 0;
      chk(t_wr == e_wr, "R2 write strobe", t_wr, e_wr);
      chk(t_rd == e_rd, "R5 read strobe", t_rd, e_rd);
      chk(t_wm == e_wm, "R7 write mode", t_wm, e_wm);
      chk(int'(mode) == e_md, "R4 mode", mode, e_md);
      chk(irq == m_irq, "R9 irq", irq, m_irq);
      chk(int'(fix_cnt) == m_cnt, "R8 count", fix_cnt, m_cnt);
      chk(int'(last_fr) == m_last, "R8 last frame", last_fr, m_last);
      if (e_wr || e_rd) begin
        chk(int'(t_frame) == m_fr, "R7 frame address", t_frame, m_fr);
        chk(int'(t_byte) == m_by, "R5 byte index", t_byte, m_by);
      end
      if (e_wr) begin
        automatic int e_d = (m_by < FB) ? int'(gcfg[m_fr * FB + m_by]) : 0;
        chk(int'(t_dout) == e_d, "R3 write data", t_dout, e_d);
        if (m_by < FB) n_cfg_wr++; else n_pad_wr++;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load();
    cmd_load = 1'b1; @(negedge clk); cmd_load = 1'b0;
  endtask

  task automatic pulse_scrub();
    cmd_scrub = 1'b1; @(negedge clk); cmd_scrub = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int k = 0;
    while (!irq && k < 400) begin @(negedge clk); k++; end
    chk(irq == 1'b1, req, irq, 1);
  endtask

  task automatic wait_mode(input int m);
    int k = 0;
    while (int'(mode) != m && k < 400) begin @(negedge clk); k++; end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NB; i++) begin
      gcfg[i]  = 8'((i * 29 + 7) ^ (i << 4));
      gmask[i] = (i == 5) ? 8'h7F : 8'hFF;
      for (int k = 0; k < 8; k++) begin
        fmem[i][2*k]   = gcfg[i][k];
        fmem[i][2*k+1] = gmask[i][k];
      end
      tmem[i] = 8'hA5;
    end
    step(3);
    chk(mode == 2'd0 && !irq && fix_cnt == '0, "R1 reset status", mode, 0);
    chk(!t_wr && !t_rd && !f_rd && !t_wm, "R1 reset strobes", t_wr | t_rd | f_rd, 0);
    rst_n = 1'b1;
    step(2);

    // R10: scrub command in idle has no effect
    pulse_scrub();
    step(4);
    chk(mode == 2'd0 && !t_rd, "R10 scrub in idle", mode, 0);

    // R2/R3: load without auto scrub
    pulse_load();
    chk(mode == 2'd1 && t_wm && !t_wr, "R2 write mode before strobe", t_wr, 0);
    wait_mode(0);
    for (int i = 0; i < NB; i++) chk(tmem[i] == gcfg[i], "R3 loaded byte", tmem[i], gcfg[i]);
    chk(n_cfg_wr == NB, "R2 config bytes", n_cfg_wr, NB);
    chk(n_pad_wr == FR * PB, "R2 pad bytes", n_pad_wr, FR * PB);
    step(10);
    chk(mode == 2'd0 && !t_rd, "R4 stays loaded without auto", mode, 0);

    // R5: readback runs cleanly
    pulse_scrub();
    chk(mode == 2'd2 && t_rd && t_frame == '0 && t_byte == '0, "R5 readback start", t_frame, 0);
    step(3 * NB);
    chk(!irq && fix_cnt == '0, "R5 clean loops", fix_cnt, 0);

    // R6: difference in a masked bit is ignored
    tmem[5] = tmem[5] ^ 8'h80;
    step(3 * NB);
    chk(!irq && fix_cnt == '0, "R6 masked flip ignored", fix_cnt, 0);
    chk(tmem[5] != gcfg[5], "R6 masked byte untouched", tmem[5], gcfg[5] ^ 8'h80);

    // R7/R8: unmasked flip in frame 2
    tmem[2 * FB + 1] = tmem[2 * FB + 1] ^ 8'h08;
    wait_irq("R8 irq after fix frame 2");
    chk(int'(fix_cnt) == 1 && int'(last_fr) == 2, "R8 count and last frame", last_fr, 2);
    chk(tmem[2 * FB + 1] == gcfg[2 * FB + 1], "R7 frame rewritten", tmem[2 * FB + 1], gcfg[2 * FB + 1]);
    chk(t_rd && int'(t_frame) == 2 && t_byte == '0, "R7 resume same frame", t_frame, 2);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    chk(!irq, "R9 read clears irq", irq, 0);

    // R7: flip in the last frame, then wrap to frame 0
    tmem[3 * FB + 3] = tmem[3 * FB + 3] ^ 8'h01;
    wait_irq("R8 irq after fix last frame");
    chk(int'(last_fr) == 3 && int'(fix_cnt) == 2, "R8 last frame 3", last_fr, 3);
    chk(t_rd && int'(t_frame) == 3, "R7 resume last frame", t_frame, 3);
    step(FB);
    chk(t_rd && t_frame == '0, "R5 wrap to frame 0", t_frame, 0);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;

    // R10: load during readback ignored
    pulse_load();
    step(4);
    chk(mode == 2'd2 && !t_wr && !t_wm, "R10 load while scrubbing", mode, 2);

    // R9: correction completing while status strobe held
    stat_rd = 1'b1;
    tmem[0] = tmem[0] ^ 8'h02;
    wait_irq("R9 set wins over clear");
    @(negedge clk);
    chk(!irq, "R9 cleared next cycle", irq, 0);
    stat_rd = 1'b0;
    chk(int'(fix_cnt) == 3, "R8 count at top", fix_cnt, 3);

    // R8: saturation
    tmem[FB] = tmem[FB] ^ 8'h10;
    wait_irq("R8 irq at saturation");
    chk(int'(fix_cnt) == 3 && int'(last_fr) == 1, "R8 count saturates", fix_cnt, 3);
    chk(tmem[5] == gcfg[5], "R7 full frame restored", tmem[5], gcfg[5]);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;

    // R4: auto scrub after a fresh load
    rst_n = 1'b0;
    step(2);
    chk(mode == 2'd0 && fix_cnt == '0 && !irq, "R1 reset again", fix_cnt, 0);
    rst_n = 1'b1;
    auto_scrub = 1'b1;
    step(1);
    pulse_load();
    wait_mode(2);
    chk(mode == 2'd2 && t_rd && t_frame == '0 && t_byte == '0, "R4 auto start", mode, 2);
    step(2 * NB);
    chk(!irq, "R4 clean after auto", irq, 0);
    finish_run();
  end
endmodule